// File: doc/BRIEF.md
# Multi-Policy DRAM Read Scheduler

This block sequences a batch of read requests onto one DRAM channel that has several banks. Requests enter through a valid/ready port while the scheduler is idle. Each request carries a thread number, a bank and a row. A `start` pulse freezes the queue, latches the ordering policy and begins a run. During the run the block tracks the open row and the busy time of every bank. It issues one precharge, activate or read command per cycle on the shared command/address bus. Each read returns as a five-cycle burst on the shared data bus. One cycle equals one nanosecond.

Three orderings can be selected. Oldest-first serves requests in arrival order. Hit-first prefers reads to an already open row and breaks ties by age. Thread-ranked first ranks the threads by how little bank-parallel work each one needs, serves the better-ranked thread entirely, and then serves the others. For each thread the block reports the time at which its last data beat ended, counted from the first cycle of the run. The queue empties when the run ends.

The request port applies back-pressure. `req_ready` is low while a run is in progress, while the queue holds `QUEUE_DEPTH` entries, and in the cycle where `start` is high. A request is accepted only on a cycle where `req_valid` and `req_ready` are both high. The data bus cannot be stalled, so the return signals are plain pulses and have no ready input.

Top module: `dram_req_sched`

## Requirements
- R1: After reset, `req_ready`=1, `busy`=0, `cmd_valid`=0, `data_valid`=0, `done_valid`=0, and every stall time is 0.
- R2: Any command to a bank makes that bank refuse precharge and activate for the next 9 cycles. A read to a closed bank is an activate at cycle t, followed by the read no earlier than t+10.
- R3: A read whose row differs from the bank's open row first needs a precharge, then an activate 10 cycles later, then the read 10 cycles after that. A read is only ever issued to the bank's open row.
- R4: A row hit that follows a read to the same bank issues 5 cycles after that read, not 10.
- R5: A read issued at cycle t puts data on the bus in cycles t+10 to t+14. Bursts never overlap, so two reads on the channel are at least 5 cycles apart.
- R6: `done_valid` pulses on a request's last data beat with `done_slot` and `done_thread`. A thread's stall time is one plus the cycle index of the last beat of its last request. Cycle 0 is the first cycle after `start` is sampled.
- R7: Policy code 0 (oldest-first) makes each bank serve its oldest request first. One command issues per cycle. When several banks can legally issue, the candidate with the highest priority wins. Priority is set by the policy and then by age, where a lower slot number means older.
- R8: Policy code 1 (hit-first) serves, within a bank, a request to the open row before any older request that misses it. Ties are broken by age.
- R9: Policy code 2 (thread-ranked) ranks threads by their largest per-bank request count, then by total request count, then by lower thread number. Rank outweighs row hits, and row hits outweigh age.
- R10: A request is stored on a `req_valid`&&`req_ready` cycle. `req_ready` falls when `QUEUE_DEPTH` entries are held.
- R11: Different banks overlap their busy periods. Activates to two idle banks issue in consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, one tick per nanosecond |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Request can be taken |
| req_thread | input | TW | Thread number of the request |
| req_bank | input | BW | Bank of the request |
| req_row | input | ROW_W | Row of the request |
| start | input | 1 | Begin a run on the queued requests |
| policy | input | 2 | 0 oldest-first, 1 hit-first, 2 thread-ranked |
| busy | output | 1 | Run in progress |
| cmd_valid | output | 1 | Command on the bus this cycle |
| cmd_kind | output | 2 | 1 precharge, 2 activate, 3 read |
| cmd_bank | output | BW | Target bank |
| cmd_row | output | ROW_W | Row of the request that caused the command |
| cmd_slot | output | SW | Queue slot that caused the command |
| data_valid | output | 1 | Data beat on the bus |
| data_slot | output | SW | Slot owning the current beat |
| done_valid | output | 1 | Last beat of a request |
| done_slot | output | SW | Completed slot |
| done_thread | output | TW | Thread of the completed slot |
| stall_time | output | NUM_THREADS*TIME_W | Stall time per thread, thread 0 in the low bits |

## Verification
Several banks can become legal for a read in the same cycle, and only one of them can win the data-bus slot. The bench provokes this by activating two banks one cycle apart. It then checks that the second read waits exactly five cycles and that its burst follows the first burst without a gap. A precharge to one bank can also compete in the same cycle with a read to another bank. The full-queue scenario makes these meet at cycle 20, and the bench checks that the older read wins and the precharge follows one cycle later.

// File: rtl/sched_pkg.sv
package sched_pkg;
  typedef enum logic [1:0] {
    CMD_NONE = 2'd0,
    CMD_PRE  = 2'd1,
    CMD_ACT  = 2'd2,
    CMD_RD   = 2'd3
  } cmd_e;

  typedef enum logic [1:0] {
    POL_FCFS   = 2'd0,
    POL_FRFCFS = 2'd1,
    POL_BATCH  = 2'd2
  } pol_e;
endpackage

// File: rtl/bank_tracker.sv
module bank_tracker import sched_pkg::*; #(
  parameter int ROW_W     = 14,
  parameter int T_BANK    = 10,
  parameter int T_OVERLAP = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear,
  input  logic             issue,
  input  logic [1:0]       kind,
  input  logic [ROW_W-1:0] row,
  output logic             is_open,
  output logic [ROW_W-1:0] open_row,
  output logic             can_cmd,
  output logic             can_rd
);
  localparam int CW    = $clog2(T_BANK + 1);
  localparam int T_HIT = T_BANK - T_OVERLAP;

  logic [CW-1:0] busy_cnt;
  logic [CW-1:0] gap_cnt;

  assign can_cmd = (busy_cnt == '0);
  assign can_rd  = (gap_cnt == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      is_open  <= 1'b0;
      open_row <= '0;
      busy_cnt <= '0;
      gap_cnt  <= '0;
    end else if (clear) begin
      is_open  <= 1'b0;
      busy_cnt <= '0;
      gap_cnt  <= '0;
    end else if (issue) begin
      busy_cnt <= CW'(T_BANK - 1);
      case (kind)
        CMD_PRE: begin is_open <= 1'b0; gap_cnt <= CW'(T_BANK - 1); end
        CMD_ACT: begin is_open <= 1'b1; open_row <= row; gap_cnt <= CW'(T_BANK - 1); end
        default: gap_cnt <= CW'(T_HIT - 1);
      endcase
    end else begin
      if (busy_cnt != '0) busy_cnt <= busy_cnt - 1'b1;
      if (gap_cnt != '0) gap_cnt <= gap_cnt - 1'b1;
    end
  end

  // R2: precharge and activate only reach an idle bank
  assert_bank_free_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (issue && kind != CMD_RD) |-> busy_cnt == '0);

  // R3: a read always targets the open row
  assert_read_open_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (issue && kind == CMD_RD) |-> (is_open && open_row == row));
endmodule

// File: rtl/read_return.sv
module read_return #(
  parameter int SW      = 3,
  parameter int T_BANK  = 10,
  parameter int T_BURST = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          rd_issue,
  input  logic [SW-1:0] rd_slot,
  output logic          bus_free,
  output logic          data_valid,
  output logic [SW-1:0] data_slot,
  output logic          done_valid,
  output logic          ret_busy
);
  localparam int D  = T_BANK - 1;
  localparam int BW = $clog2(T_BURST + 1);

  logic [D-1:0]  pv;
  logic [SW-1:0] ps [D];
  logic [BW-1:0] beat_cnt;
  logic [BW-1:0] rsv_cnt;
  logic          load;

  assign load       = pv[D-1];
  assign bus_free   = (rsv_cnt == '0);
  assign data_valid = (beat_cnt != '0);
  assign done_valid = (beat_cnt == BW'(1));
  assign ret_busy   = (|pv) || data_valid;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pv        <= '0;
      beat_cnt  <= '0;
      rsv_cnt   <= '0;
      data_slot <= '0;
      for (int i = 0; i < D; i++) ps[i] <= '0;
    end else begin
      pv    <= {pv[D-2:0], rd_issue};
      ps[0] <= rd_slot;
      for (int i = 1; i < D; i++) ps[i] <= ps[i-1];
      if (load) begin
        beat_cnt  <= BW'(T_BURST);
        data_slot <= ps[D-1];
      end else if (beat_cnt != '0) begin
        beat_cnt <= beat_cnt - 1'b1;
      end
      if (rd_issue) rsv_cnt <= BW'(T_BURST - 1);
      else if (rsv_cnt != '0) rsv_cnt <= rsv_cnt - 1'b1;
    end
  end

  // R5: a new burst never starts while one is still on the bus
  assert_bus_serial_R5: assert property (@(posedge clk) disable iff (!rst_n)
    load |-> beat_cnt <= BW'(1));
endmodule

// File: rtl/thread_ranker.sv
module thread_ranker #(
  parameter int NT  = 2,
  parameter int NB  = 4,
  parameter int QD  = 8,
  parameter int TW  = 1,
  parameter int BW  = 2
) (
  input  logic          occ  [QD],
  input  logic [TW-1:0] thr  [QD],
  input  logic [BW-1:0] bank [QD],
  output logic [TW-1:0] rank [NT]
);
  localparam int CTW = $clog2(QD + 1);

  logic [CTW-1:0] peak [NT];
  logic [CTW-1:0] total [NT];
  logic [CTW-1:0] cnt;

  always_comb begin
    cnt = '0;
    for (int t = 0; t < NT; t++) begin
      peak[t]  = '0;
      total[t] = '0;
      for (int b = 0; b < NB; b++) begin
        cnt = '0;
        for (int s = 0; s < QD; s++)
          if (occ[s] && thr[s] == TW'(t) && bank[s] == BW'(b)) cnt = cnt + 1'b1;
        if (cnt > peak[t]) peak[t] = cnt;
        total[t] = total[t] + cnt;
      end
    end
    for (int t = 0; t < NT; t++) begin
      rank[t] = '0;
      for (int u = 0; u < NT; u++)
        if (u != t && ((peak[u] < peak[t]) ||
                       (peak[u] == peak[t] && total[u] < total[t]) ||
                       (peak[u] == peak[t] && total[u] == total[t] && u < t)))
          rank[t] = rank[t] + 1'b1;
    end
  end
endmodule

// File: rtl/dram_req_sched.sv
module dram_req_sched import sched_pkg::*; #(
  parameter int NUM_THREADS = 2,
  parameter int NUM_BANKS   = 4,
  parameter int QUEUE_DEPTH = 8,
  parameter int ROW_W       = 14,
  parameter int T_BANK      = 10,
  parameter int T_OVERLAP   = 5,
  parameter int T_BURST     = 5,
  parameter int TIME_W      = 16,
  localparam int TW = (NUM_THREADS > 1) ? $clog2(NUM_THREADS) : 1,
  localparam int BW = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1,
  localparam int SW = (QUEUE_DEPTH > 1) ? $clog2(QUEUE_DEPTH) : 1
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          req_valid,
  output logic                          req_ready,
  input  logic [TW-1:0]                 req_thread,
  input  logic [BW-1:0]                 req_bank,
  input  logic [ROW_W-1:0]              req_row,
  input  logic                          start,
  input  logic [1:0]                    policy,
  output logic                          busy,
  output logic                          cmd_valid,
  output logic [1:0]                    cmd_kind,
  output logic [BW-1:0]                 cmd_bank,
  output logic [ROW_W-1:0]              cmd_row,
  output logic [SW-1:0]                 cmd_slot,
  output logic                          data_valid,
  output logic [SW-1:0]                 data_slot,
  output logic                          done_valid,
  output logic [SW-1:0]                 done_slot,
  output logic [TW-1:0]                 done_thread,
  output logic [NUM_THREADS*TIME_W-1:0] stall_time
);
  localparam int QD  = QUEUE_DEPTH;
  localparam int NB  = NUM_BANKS;
  localparam int CTW = $clog2(QD + 1);
  localparam int KW  = 1 + TW + 1 + SW;

  logic [TW-1:0]    q_thr  [QD];
  logic [BW-1:0]    q_bank [QD];
  logic [ROW_W-1:0] q_row  [QD];
  logic             occ    [QD];
  logic [QD-1:0]    pend;
  logic [CTW-1:0]   fill;
  logic             run;
  pol_e             pol;
  logic [TIME_W-1:0] now;
  logic [TIME_W-1:0] stall [NUM_THREADS];

  logic             b_open [NB];
  logic [ROW_W-1:0] b_row  [NB];
  logic             b_cmd  [NB];
  logic             b_rd   [NB];
  logic [TW-1:0]    rank   [NUM_THREADS];

  logic [KW-1:0] key   [QD];
  logic          s_hit [QD];
  logic [KW-1:0] bkey  [NB];
  logic [SW-1:0] bslot [NB];
  cmd_e          bkind [NB];
  logic          blegal[NB];

  logic          found, iss, start_go, bus_free, ret_busy;
  logic [KW-1:0] skey;
  logic [BW-1:0] sel_bank;
  logic [SW-1:0] sel_slot;
  cmd_e          sel_kind;

  assign start_go  = start && !run && (fill != '0);
  assign req_ready = !run && !start && (fill != CTW'(QD));
  assign busy      = run;

  for (genvar s = 0; s < QD; s++) begin : g_occ
    assign occ[s] = (CTW'(s) < fill);
  end

  thread_ranker #(.NT(NUM_THREADS), .NB(NB), .QD(QD), .TW(TW), .BW(BW)) u_rank (
    .occ(occ), .thr(q_thr), .bank(q_bank), .rank(rank));

  for (genvar g = 0; g < NB; g++) begin : g_bank
    bank_tracker #(.ROW_W(ROW_W), .T_BANK(T_BANK), .T_OVERLAP(T_OVERLAP)) u_bank (
      .clk(clk), .rst_n(rst_n), .clear(start_go),
      .issue(iss && sel_bank == BW'(g)), .kind(sel_kind), .row(q_row[sel_slot]),
      .is_open(b_open[g]), .open_row(b_row[g]), .can_cmd(b_cmd[g]), .can_rd(b_rd[g]));
  end

  read_return #(.SW(SW), .T_BANK(T_BANK), .T_BURST(T_BURST)) u_ret (
    .clk(clk), .rst_n(rst_n), .rd_issue(iss && sel_kind == CMD_RD), .rd_slot(sel_slot),
    .bus_free(bus_free), .data_valid(data_valid), .data_slot(data_slot),
    .done_valid(done_valid), .ret_busy(ret_busy));

  // Priority key per slot: pending, thread rank, row hit, age
  always_comb begin
    for (int s = 0; s < QD; s++) begin
      s_hit[s] = b_open[q_bank[s]] && (b_row[q_bank[s]] == q_row[s]);
      key[s] = {pend[s],
                (pol == POL_BATCH) ? (TW'(NUM_THREADS - 1) - rank[q_thr[s]]) : TW'(0),
                (pol != POL_FCFS) && s_hit[s],
                SW'(QD - 1 - s)};
    end
  end

  // Best request per bank, then best legal bank on the command bus
  always_comb begin
    found = 1'b0; skey = '0; sel_bank = '0; sel_slot = '0; sel_kind = CMD_NONE;
    for (int b = 0; b < NB; b++) begin
      bkey[b] = '0; bslot[b] = '0;
      for (int s = 0; s < QD; s++)
        if (q_bank[s] == BW'(b) && key[s] > bkey[b]) begin
          bkey[b] = key[s]; bslot[b] = SW'(s);
        end
      bkind[b]  = !b_open[b] ? CMD_ACT : (s_hit[bslot[b]] ? CMD_RD : CMD_PRE);
      blegal[b] = (bkind[b] == CMD_RD) ? (b_rd[b] && bus_free) : b_cmd[b];
      if (bkey[b][KW-1] && blegal[b] && bkey[b] > skey) begin
        found = 1'b1; skey = bkey[b]; sel_bank = BW'(b);
        sel_slot = bslot[b]; sel_kind = bkind[b];
      end
    end
  end

  assign iss         = run && found;
  assign cmd_valid   = iss;
  assign cmd_kind    = iss ? sel_kind : CMD_NONE;
  assign cmd_bank    = sel_bank;
  assign cmd_row     = q_row[sel_slot];
  assign cmd_slot    = sel_slot;
  assign done_slot   = data_slot;
  assign done_thread = q_thr[data_slot];

  for (genvar t = 0; t < NUM_THREADS; t++) begin : g_stall
    assign stall_time[t*TIME_W +: TIME_W] = stall[t];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fill <= '0; run <= 1'b0; pol <= POL_FCFS; now <= '0; pend <= '0;
      for (int s = 0; s < QD; s++) begin q_thr[s] <= '0; q_bank[s] <= '0; q_row[s] <= '0; end
      for (int t = 0; t < NUM_THREADS; t++) stall[t] <= '0;
    end else if (start_go) begin
      run <= 1'b1; now <= '0; pol <= pol_e'(policy);
      for (int s = 0; s < QD; s++) pend[s] <= occ[s];
      for (int t = 0; t < NUM_THREADS; t++) stall[t] <= '0;
    end else if (run) begin
      now <= now + 1'b1;
      if (iss && sel_kind == CMD_RD) pend[sel_slot] <= 1'b0;
      if (done_valid) stall[q_thr[data_slot]] <= now + 1'b1;
      if (pend == '0 && !ret_busy) begin run <= 1'b0; fill <= '0; end
    end else if (req_valid && req_ready) begin
      q_thr[fill[SW-1:0]]  <= req_thread;
      q_bank[fill[SW-1:0]] <= req_bank;
      q_row[fill[SW-1:0]]  <= req_row;
      fill <= fill + 1'b1;
    end
  end

  // R10: every accepted request grows the queue by one
  assert_push_count_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> fill == $past(fill) + 1'b1);

  // R6: a completing slot had its read issued earlier
  assert_done_issued_R6: assert property (@(posedge clk) disable iff (!rst_n)
    done_valid |-> !pend[data_slot]);
endmodule

// File: tb/dram_req_sched_tb.sv
module dram_req_sched_tb;
  localparam int CLK_PERIOD = 10;
  localparam int CW = 16;

  logic clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  logic rst_n, req_valid, req_ready, start, busy;
  logic [0:0] req_thread, done_thread;
  logic [1:0] req_bank, policy, cmd_kind, cmd_bank;
  logic [13:0] req_row, cmd_row;
  logic [2:0] cmd_slot, data_slot, done_slot;
  logic cmd_valid, data_valid, done_valid;
  logic [2*CW-1:0] stall_time;

  dram_req_sched u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_thread(req_thread), .req_bank(req_bank), .req_row(req_row),
    .start(start), .policy(policy), .busy(busy),
    .cmd_valid(cmd_valid), .cmd_kind(cmd_kind), .cmd_bank(cmd_bank),
    .cmd_row(cmd_row), .cmd_slot(cmd_slot), .data_valid(data_valid),
    .data_slot(data_slot), .done_valid(done_valid), .done_slot(done_slot),
    .done_thread(done_thread), .stall_time(stall_time));

  int checks = 0, errors = 0;
  int ev_kind [64], ev_slot [64], ev_time [64], ev_row [64];
  int nev, tcount;
  int done_t [8], done_thr [8];
  bit mon_on = 0;

  localparam int PRE = 1, ACT = 2, RD = 3;

  always @(negedge clk) begin
    if (mon_on) begin
      if (cmd_valid && nev < 64) begin
        ev_kind[nev] = int'(cmd_kind); ev_slot[nev] = int'(cmd_slot);
        ev_time[nev] = tcount; ev_row[nev] = int'(cmd_row);
        nev++;
      end
      if (done_valid) begin
        done_t[done_slot] = tcount; done_thr[done_slot] = int'(done_thread);
      end
      tcount++;
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int tfind(input int k, input int s);
    for (int i = 0; i < nev; i++)
      if (ev_kind[i] == k && ev_slot[i] == s) return ev_time[i];
    return -1;
  endfunction

  function automatic int rowfind(input int k, input int s);
    for (int i = 0; i < nev; i++)
      if (ev_kind[i] == k && ev_slot[i] == s) return ev_row[i];
    return -1;
  endfunction

  function automatic int stall_of(input int t);
    return int'(stall_time[t*CW +: CW]);
  endfunction

  task automatic push(input int thr, input int bank, input int row);
    @(negedge clk);
    req_valid = 1'b1;
    req_thread = thr[0:0]; req_bank = bank[1:0]; req_row = row[13:0];
  endtask

  task automatic run(input int pol);
    int guard;
    @(negedge clk);
    req_valid = 1'b0; start = 1'b1; policy = pol[1:0];
    for (int i = 0; i < 8; i++) begin done_t[i] = -1; done_thr[i] = -1; end
    @(posedge clk);
    nev = 0; tcount = 0; mon_on = 1;
    @(negedge clk);
    start = 1'b0;
    guard = 0;
    while (busy && guard < 3000) begin @(negedge clk); guard++; end
    mon_on = 0;
    if (guard >= 3000) begin
      checks++; errors++;
      $display("FAIL watchdog actual %0d expected %0d", guard, 0);
    end
  endtask

  task automatic t_reset;
    chk("R1 req_ready", int'(req_ready), 1);
    chk("R1 busy", int'(busy), 0);
    chk("R1 cmd_valid", int'(cmd_valid), 0);
    chk("R1 data_valid", int'(data_valid), 0);
    chk("R1 done_valid", int'(done_valid), 0);
    chk("R1 stall", int'(stall_time), 0);
  endtask

  task automatic t_single;
    push(0, 0, 5);
    run(0);
    chk("R2 act time", tfind(ACT, 0), 0);
    chk("R2 read after act", tfind(RD, 0), 10);
    chk("R5 done cycle", done_t[0], 24);
    chk("R6 done thread", done_thr[0], 0);
    chk("R6 stall t0", stall_of(0), 25);
    chk("R6 stall t1 unused", stall_of(1), 0);
  endtask

  task automatic t_hits;
    push(0, 2, 3); push(0, 2, 3);
    run(0);
    chk("R4 first read", tfind(RD, 0), 10);
    chk("R4 pipelined hit", tfind(RD, 1), 15);
    chk("R4 no extra act", tfind(ACT, 1), -1);
    chk("R6 stall hits", stall_of(0), 30);
  endtask

  task automatic t_conflict;
    push(0, 0, 1); push(1, 0, 2);
    run(0);
    chk("R3 precharge", tfind(PRE, 1), 20);
    chk("R3 activate", tfind(ACT, 1), 30);
    chk("R3 act row", rowfind(ACT, 1), 2);
    chk("R3 read", tfind(RD, 1), 40);
    chk("R6 stall t0", stall_of(0), 25);
    chk("R6 stall t1", stall_of(1), 55);
  endtask

  task automatic t_two_banks;
    push(0, 0, 0); push(1, 1, 0);
    run(0);
    chk("R11 act bank0", tfind(ACT, 0), 0);
    chk("R11 act bank1", tfind(ACT, 1), 1);
    chk("R5 first read", tfind(RD, 0), 10);
    chk("R5 bus wait read", tfind(RD, 1), 15);
    chk("R5 second done", done_t[1], 29);
    chk("R6 stall t1", stall_of(1), 30);
  endtask

  task automatic t_order(input int pol);
    push(1, 0, 0); push(0, 0, 7); push(1, 0, 0);
    run(pol);
    if (pol == 0) begin
      chk("R7 oldest first read", tfind(RD, 1), 40);
      chk("R7 young hit waits", tfind(RD, 2), 70);
      chk("R7 stall t0", stall_of(0), 55);
      chk("R7 stall t1", stall_of(1), 85);
    end else begin
      chk("R8 hit jumps", tfind(RD, 2), 15);
      chk("R8 miss later", tfind(PRE, 1), 25);
      chk("R8 stall t0", stall_of(0), 60);
      chk("R8 stall t1", stall_of(1), 30);
    end
  endtask

  task automatic t_batch(input int pol);
    push(0, 0, 0); push(0, 0, 0); push(0, 0, 0); push(1, 1, 2);
    run(pol);
    if (pol == 2) begin
      chk("R9 ranked act", tfind(ACT, 3), 0);
      chk("R9 ranked read", tfind(RD, 3), 10);
      chk("R9 other read", tfind(RD, 0), 15);
      chk("R9 stall t1", stall_of(1), 25);
      chk("R9 stall t0", stall_of(0), 40);
    end else begin
      chk("R7 age order read", tfind(RD, 3), 25);
      chk("R7 stall t1", stall_of(1), 40);
      chk("R7 stall t0", stall_of(0), 35);
    end
  endtask

  task automatic t_full;
    for (int i = 0; i < 8; i++) push(0, i % 4, i);
    @(negedge clk);
    req_valid = 1'b0;
    @(negedge clk);
    chk("R10 ready low when full", int'(req_ready), 0);
    run(0);
    chk("R7 read beats precharge", tfind(RD, 2), 20);
    chk("R7 precharge next", tfind(PRE, 4), 21);
    chk("R5 late read", tfind(RD, 7), 56);
    chk("R6 all done", done_t[7], 70);
    chk("R6 stall full", stall_of(0), 71);
    chk("R10 ready after run", int'(req_ready), 1);
  endtask

  initial begin
    rst_n = 1'b0; req_valid = 1'b0; start = 1'b0; policy = 2'd0;
    req_thread = '0; req_bank = '0; req_row = '0;
    repeat (3) @(negedge clk);
    t_reset;
    rst_n = 1'b1;
    @(negedge clk);
    t_reset;
    t_single;
    t_hits;
    t_conflict;
    t_two_banks;
    t_order(0);
    t_order(1);
    t_batch(2);
    t_batch(0);
    t_full;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule